// File: doc/BRIEF.md
# Embedded-Clock Serial Framer Transmitter

This block turns a stream of 10-bit parallel words into a serial line in which every word travels as a 12-bit frame. Each frame opens with a 1 and closes with a 0. This guarantees one rising edge per frame that a receiver can recover timing from. Serial bits leave one per pulse of a bit-rate enable that runs at twelve times the word rate, so ten of every twelve line bits carry payload.

A word is captured on a selectable edge of a word clock. That clock is sampled in the fast clock domain. The captured word is framed at the next frame boundary. Two link-training request inputs are ORed together. While a request is active, and for a guaranteed minimum of frames after one is seen, the block sends training frames instead of data. A training frame is six ones followed by six zeros. The line is modelled as a data bit plus a drive flag. An output enable and a powerdown input both release the line.

Top module: `embclk_framer_tx`

## Requirements
- R1: A data frame leaves least significant bit first as 12 line bits: bit 0 is 1 (start), bits 1..10 carry the captured word with word bit 0 first, bit 11 is 0 (stop). The line advances one bit per clock in which `bitEn` is high and holds its bit when `bitEn` is low.
- R2: Frames follow back to back with no idle bits. Each frame boundary loads the word most recently captured.
- R3: A training frame carries 1 in transmit positions 0..5 and 0 in positions 6..11.
- R4: Either `syncReqA` or `syncReqB`, alone, selects training frames.
- R5: When a request is seen in a cycle that is not a frame boundary, exactly 1024 training frames follow, even if the request lasts one cycle. While a request stays high, training frames continue. The count of 1024 restarts from the last frame boundary at which a request was high.
- R6: `dataIn` has no effect on the line while training frames are sent.
- R7: With `edgeSel` high the word is captured on a rising edge of `wordClk`, with it low on a falling edge; the opposite edge captures nothing.
- R8: With `outEn` low, `serOe` and `serOut` are 0 and framing continues unseen. When `outEn` returns high, the line shows the bit of the frame that is then current.
- R9: With `pwrOn` low, `serOe` is 0, capture stops and framing halts. The first `bitEn` after `pwrOn` rises starts a new frame.
- R10: Synchronous active-low reset clears the captured word and the training counter and releases the line. The first `bitEn` after reset starts a data frame carrying word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitEn | input | 1 | Line-bit enable, 12 per word period |
| wordClk | input | 1 | Word clock, sampled in the `clk` domain |
| edgeSel | input | 1 | 1: capture on rising `wordClk`, 0: on falling |
| dataIn | input | 10 | Parallel word |
| syncReqA | input | 1 | Training request, first source |
| syncReqB | input | 1 | Training request, second source |
| outEn | input | 1 | Line drive enable |
| pwrOn | input | 1 | 0 puts the block in powerdown |
| serOut | output | 1 | Serial line bit, 0 while not driven |
| serOe | output | 1 | 1 when the line is driven |

## Verification
The in-line properties watch the cycle-level mechanics on every cycle:
- the frame position steps by one per enable;
- the training counter arms on any request and counts down one per boundary;
- every loaded data frame has its start and stop bits, and every loaded training frame has its six-and-six shape;
- at most one of load or shift happens in any cycle;
- the line stays released after powerdown.

Only the bench scenarios can show the end-to-end effects:
- the exact 1024-frame tail after a short request, and the longer run after a held request;
- that words offered during training never appear on the line;
- edge selection in both polarities;
- resumption mid-frame after the enable returns;
- the fresh frame, carrying the pre-powerdown word, after wake-up.

// File: rtl/embclk_framer_pkg.sv
package embclk_framer_pkg;

  typedef struct packed {
    logic capture;
    logic loadData;
    logic loadSync;
    logic shift;
    logic drive;
  } txStrobe_t;

endpackage

// File: rtl/embclk_framer_ctrl.sv
module embclk_framer_ctrl
  import embclk_framer_pkg::*;
#(
  parameter int FRAME_W  = 12,
  parameter int SYNC_MIN = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrOn,
  input  logic      outEn,
  input  logic      bitEn,
  input  logic      wordClk,
  input  logic      edgeSel,
  input  logic      syncReqA,
  input  logic      syncReqB,
  output txStrobe_t stb
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam int CNT_W = $clog2(SYNC_MIN + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] syncLeft;
  logic live;
  logic wcPrev;

  logic req, atLast, boundary, sendSync, edgeHit;

  assign req      = syncReqA | syncReqB;
  assign atLast   = (bitIdx == LAST);
  assign boundary = pwrOn & bitEn & atLast;
  assign sendSync = req | (syncLeft != '0);
  assign edgeHit  = edgeSel ? (wordClk & ~wcPrev) : (~wordClk & wcPrev);

  always_comb begin
    stb.capture  = pwrOn & edgeHit;
    stb.loadData = boundary & ~sendSync;
    stb.loadSync = boundary & sendSync;
    stb.shift    = pwrOn & bitEn & ~atLast;
    stb.drive    = live & outEn & pwrOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx   <= LAST;
      syncLeft <= '0;
      live     <= 1'b0;
      wcPrev   <= 1'b0;
    end else begin
      wcPrev <= wordClk;
      if (!pwrOn) begin
        bitIdx <= LAST;
        live   <= 1'b0;
      end else begin
        if (bitEn) bitIdx <= atLast ? '0 : bitIdx + 1'b1;
        if (boundary) live <= 1'b1;
        if (req) syncLeft <= boundary ? CNT_W'(SYNC_MIN - 1) : CNT_W'(SYNC_MIN);
        else if (boundary && syncLeft != '0) syncLeft <= syncLeft - 1'b1;
      end
    end
  end

  // R1: position steps by one per enable inside a frame
  a_r1_bit_step: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOn && bitEn && !atLast) |=> (bitIdx == IDX_W'($past(bitIdx) + 1'b1)));

  // R5: any request arms at least a full training tail
  a_r5_sync_armed: assert property (@(posedge clk) disable iff (!rstN)
    (req && pwrOn) |=> (syncLeft >= CNT_W'(SYNC_MIN - 1)));

  // R5: tail shrinks by exactly one per boundary without a request
  a_r5_sync_step: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !req && syncLeft != '0) |=> (syncLeft == CNT_W'($past(syncLeft) - 1'b1)));

  // R9: line released in the cycle after powerdown
  a_r9_pd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |=> !stb.drive);

endmodule

// File: rtl/embclk_framer_dpath.sv
module embclk_framer_dpath
  import embclk_framer_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              serOut,
  output logic              serOe
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF    = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] SYNC_PAT = {{(FRAME_W - HALF){1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0]  capt;
  logic [FRAME_W-1:0] shifter;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capt    <= '0;
      shifter <= '0;
    end else begin
      if (stb.capture) capt <= dataIn;
      if (stb.loadSync)      shifter <= SYNC_PAT;
      else if (stb.loadData) shifter <= {1'b0, capt, 1'b1};
      else if (stb.shift)    shifter <= {1'b0, shifter[FRAME_W-1:1]};
    end
  end

  assign serOut = stb.drive & shifter[0];
  assign serOe  = stb.drive;

  // R1: loaded data frame has start high and stop low
  a_r1_frame_edges: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadData |=> (shifter[0] && !shifter[FRAME_W-1]));

  // R3: loaded training frame has the six-and-six shape
  a_r3_sync_shape: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadSync |=> (shifter == SYNC_PAT));

  // R2: load and shift never collide
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadData, stb.loadSync, stb.shift}));

endmodule

// File: rtl/embclk_framer_tx.sv
module embclk_framer_tx
  import embclk_framer_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SYNC_MIN = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              wordClk,
  input  logic              edgeSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              syncReqA,
  input  logic              syncReqB,
  input  logic              outEn,
  input  logic              pwrOn,
  output logic              serOut,
  output logic              serOe
);
  localparam int FRAME_W = DATA_W + 2;

  txStrobe_t stb;

  embclk_framer_ctrl #(.FRAME_W(FRAME_W), .SYNC_MIN(SYNC_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrOn(pwrOn), .outEn(outEn), .bitEn(bitEn),
    .wordClk(wordClk), .edgeSel(edgeSel), .syncReqA(syncReqA),
    .syncReqB(syncReqB), .stb(stb)
  );

  embclk_framer_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .serOut(serOut), .serOe(serOe)
  );

endmodule

// File: tb/embclk_framer_tx_tb.sv
module embclk_framer_tx_tb;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = DATA_W + 2;
  localparam logic [FRAME_W-1:0] SYNC_F = 12'h03F;

  typedef struct {
    logic [FRAME_W-1:0] frame;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN, bitEn, wordClk, edgeSel, syncReqA, syncReqB, outEn, pwrOn;
  logic [DATA_W-1:0] dataIn;
  logic serOut, serOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit monOn = 0;
  int bitsGot = 0;
  logic [FRAME_W-1:0] gotFrame;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  embclk_framer_tx u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .wordClk(wordClk), .edgeSel(edgeSel),
    .dataIn(dataIn), .syncReqA(syncReqA), .syncReqB(syncReqB), .outEn(outEn),
    .pwrOn(pwrOn), .serOut(serOut), .serOe(serOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: collect 12 driven bits, compare with scoreboard front
  always @(negedge clk) begin
    if (monOn && serOe) begin
      gotFrame[bitsGot] = serOut;
      bitsGot++;
      if (bitsGot == FRAME_W) begin
        expItem_t e;
        bitsGot = 0;
        if (expQ.size() == 0) check(1'b0, "R2 unexpected frame", 32'(gotFrame), 0);
        else begin
          e = expQ.pop_front();
          check(gotFrame == e.frame, e.tag, 32'(gotFrame), 32'(e.frame));
        end
      end
    end
  end

  task automatic playFrame(input logic [DATA_W-1:0] w, input bit expSync,
                           input bit pulseA, input bit bLvl, input bit doPush,
                           input string tag);
    expItem_t e;
    @(negedge clk);
    dataIn = w; wordClk = edgeSel; syncReqB = bLvl;
    if (pulseA) syncReqA = 1'b1;
    @(negedge clk);
    syncReqA = 1'b0;
    repeat (4) @(negedge clk);
    wordClk = ~edgeSel; dataIn = ~w;
    repeat (6) @(negedge clk);
    if (doPush) begin
      e.frame = expSync ? SYNC_F : {1'b0, w, 1'b1};
      e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    expItem_t e0;
    logic [DATA_W-1:0] wA;
    logic [FRAME_W-1:0] fA;
    rstN = 0; bitEn = 1; wordClk = 0; edgeSel = 1; syncReqA = 0; syncReqB = 0;
    outEn = 1; pwrOn = 1; dataIn = '0;
    repeat (3) @(negedge clk);
    check(serOe == 1'b0, "R10 line released in reset", serOe, 0);
    check(serOut == 1'b0, "R10 line low in reset", serOut, 0);
    e0.frame = {1'b0, {DATA_W{1'b0}}, 1'b1}; e0.tag = "R10 first frame";
    expQ.push_back(e0);
    rstN = 1; monOn = 1;

    // data frames on the rising edge
    playFrame(10'h2A5, 0, 0, 0, 1, "R1 data frame");
    playFrame(10'h3FF, 0, 0, 0, 1, "R1 all ones");
    playFrame(10'h000, 0, 0, 0, 1, "R1 all zeros");
    playFrame(10'h001, 0, 0, 0, 1, "R2 back to back");
    playFrame(10'h200, 0, 0, 0, 1, "R7 rising edge capture");

    // one-cycle request on A: exactly 1024 training frames
    playFrame(10'h111, 1, 1, 0, 1, "R5 short request");
    for (int j = 1; j < 1024; j++)
      playFrame(DATA_W'(j * 7), 1, 0, 0, 1, "R6 data ignored in training");
    playFrame(10'h0F0, 0, 0, 0, 1, "R5 data resumes after 1024");

    // request held on B for three frames: 1026 training frames
    for (int j = 0; j < 3; j++)
      playFrame(DATA_W'(j + 5), 1, 0, 1, 1, "R4 second request source");
    for (int j = 3; j < 1026; j++)
      playFrame(DATA_W'(j * 3), 1, 0, 0, 1, "R4 tail after held request");
    playFrame(10'h1C3, 0, 0, 0, 1, "R5 data after held tail");

    // falling-edge capture
    edgeSel = 0; wordClk = 1;
    playFrame(10'h155, 0, 0, 0, 1, "R7 falling edge capture");
    playFrame(10'h2AA, 0, 0, 0, 1, "R7 falling edge capture");
    playFrame(10'h07E, 0, 0, 0, 1, "R7 falling edge capture");

    // output enable: frame keeps running unseen
    wA = 10'h2C6; fA = {1'b0, wA, 1'b1};
    playFrame(wA, 0, 0, 0, 0, "R8");
    @(posedge clk);
    monOn = 0; outEn = 0;
    check(expQ.size() == 0 && bitsGot == 0, "R2 scoreboard drained", expQ.size(), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(serOe == 1'b0, "R8 line released", serOe, 0);
      check(serOut == 1'b0, "R8 line low", serOut, 0);
    end
    outEn = 1;
    for (int i = 5; i < FRAME_W; i++) begin
      @(negedge clk);
      check(serOe == 1'b1 && serOut == fA[i], "R8 resume mid-frame", {serOe, serOut}, {1'b1, fA[i]});
    end

    // powerdown: no capture, restart with a fresh frame
    pwrOn = 0; wordClk = 0; dataIn = 10'h155;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(serOe == 1'b0, "R9 released in powerdown", serOe, 0);
      if (i == 1) wordClk = 1;
    end
    pwrOn = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(serOe == 1'b1 && serOut == fA[i], "R9 fresh frame after wake", {serOe, serOut}, {1'b1, fA[i]});
    end
    bitEn = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(serOut == fA[3], "R1 bit held without enable", serOut, fA[3]);
    end
    bitEn = 1;
    for (int i = 4; i < FRAME_W; i++) begin
      @(negedge clk);
      check(serOut == fA[i], "R9 frame continues", serOut, fA[i]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule